// File: doc/BRIEF.md
# UART FIFO Interrupt Flag Controller

This block keeps the status flags and interrupt request logic of a UART whose transmit and receive paths are buffered by FIFOs. It does not contain the FIFOs, shifters or baud logic. It watches the fill count of each FIFO against a programmable trigger level, and it takes single-cycle event pulses for received-data-ready, receive error and line break. It turns these into five sticky status flags. A small register port lets the CPU read the flags and write two enable bits.

The flags drive four separate interrupt lines: transmit, receive, receive error and break. Two DMA request lines come from the transmit-empty and receive-full flags only. The block also gives an encoded output naming the highest-priority line that is asserted, using a fixed order. A flag can be cleared in two ways. Software can clear it by reading the flag as 1 and then writing 0 to it. For the two FIFO flags, a DMA access can also clear it automatically once the access has moved the fill level past the trigger.

Top module: `uart_irq_flags`

## Requirements
- R1: After reset the status register (regAddr=0) reads 5'b00001, the control register (regAddr=1) reads 0, and no interrupt, DMA or priority-valid output is asserted.
- R2: Status bit 0 (transmit empty) becomes 1 on the cycle after txCount <= txTrig. Status bit 1 (receive full) becomes 1 on the cycle after rxCount >= rxTrig.
- R3: A pulse on dataReadyEvt, rxErrEvt or breakEvt sets status bit 2, bit 3 or bit 4 respectively on the next cycle. The flag then stays set.
- R4: A status write with a bit at 0 clears that flag only if a status read has returned that bit as 1 since the flag was last set. Otherwise the write leaves the flag unchanged.
- R5: Writing 1 to a status bit never changes that flag.
- R6: A dmaTxAck pulse while txCount > txTrig clears the transmit-empty flag. While txCount <= txTrig the pulse has no effect.
- R7: A dmaRxAck pulse while rxCount < rxTrig clears the receive-full flag. While rxCount >= rxTrig the pulse has no effect.
- R8: The control register is 2 bits wide: bit 0 is the transmit enable and bit 1 is the receive enable. The outputs follow these rules: irqTx = bit0 & transmit-enable; irqRx = (bit1 | bit2) & receive-enable; irqErr = bit3 & receive-enable; irqBrk = bit4 & receive-enable.
- R9: The DMA outputs follow these rules: dmaTxReq = bit0 & transmit-enable, and dmaRxReq = bit1 & receive-enable. The data-ready, error and break flags never raise a DMA request.
- R10: topValid is 1 when any interrupt line is asserted. topCode then names the highest asserted line, with codes 0 = error, 1 = receive, 2 = break, 3 = transmit, in that order of priority.
- R11: When a FIFO level condition holds in the same cycle as a clear, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txCount | input | CNT_W | Transmit FIFO fill count |
| rxCount | input | CNT_W | Receive FIFO fill count |
| txTrig | input | CNT_W | Transmit trigger level |
| rxTrig | input | CNT_W | Receive trigger level |
| dmaTxAck | input | 1 | DMA wrote the transmit FIFO this cycle |
| dmaRxAck | input | 1 | DMA read the receive FIFO this cycle |
| dataReadyEvt | input | 1 | Received-data-ready event pulse |
| rxErrEvt | input | 1 | Receive error event pulse |
| breakEvt | input | 1 | Line break event pulse |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = status, 1 = control |
| regWdata | input | 5 | Write data |
| regRdata | output | 5 | Read data of the selected register |
| irqTx | output | 1 | Transmit interrupt request |
| irqRx | output | 1 | Receive interrupt request |
| irqErr | output | 1 | Receive error interrupt request |
| irqBrk | output | 1 | Break interrupt request |
| dmaTxReq | output | 1 | Transmit DMA request |
| dmaRxReq | output | 1 | Receive DMA request |
| topValid | output | 1 | Some interrupt line is asserted |
| topCode | output | 2 | Highest-priority asserted line |

## Verification
The assertions assume that a break flag can only fall because of a status write with bit 4 at 0. They also assume that an all-ones status write coinciding with no DMA pulse removes no flag. Both assumptions rely on the DMA acknowledge pulses being the only other clearing path. The stimulus never raises read and write strobes in the same cycle, and it keeps counts and triggers within CNT_W bits. Before each case, the bench moves the FIFO counts to neutral values (transmit count above its trigger, receive count below its trigger) so that level-set conditions do not mask the clear under test.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int FLAG_N = 5;
  localparam int F_TXE  = 0;
  localparam int F_RXF  = 1;
  localparam int F_DRDY = 2;
  localparam int F_ERR  = 3;
  localparam int F_BRK  = 4;
  localparam logic [FLAG_N-1:0] FLAG_RST = 5'b00001;

  typedef struct packed {
    logic              rdStatus;
    logic              wrStatus;
    logic [FLAG_N-1:0] wrBits;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SRC_ERR = 2'd0,
    SRC_RX  = 2'd1,
    SRC_BRK = 2'd2,
    SRC_TX  = 2'd3
  } irqSrc_e;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regRd,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [FLAG_N-1:0] regWdata,
  output regStrobe_t        strobe,
  output logic              txIe,
  output logic              rxIe
);
  logic selStatus;
  assign selStatus = (regAddr == 1'b0);

  always_comb begin
    strobe.rdStatus = regRd & selStatus;
    strobe.wrStatus = regWr & selStatus;
    strobe.wrBits   = regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txIe <= 1'b0;
      rxIe <= 1'b0;
    end else if (regWr && !selStatus) begin
      txIe <= regWdata[0];
      rxIe <= regWdata[1];
    end
  end
endmodule

// File: rtl/uirq_flags.sv
module uirq_flags
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txTrig,
  input  logic [CNT_W-1:0]  rxTrig,
  input  logic              dmaTxAck,
  input  logic              dmaRxAck,
  input  logic              dataReadyEvt,
  input  logic              rxErrEvt,
  input  logic              breakEvt,
  output logic [FLAG_N-1:0] flagVec
);
  logic [FLAG_N-1:0] setVec, dmaClr, swClr, armQ, flagNext, armNext;

  always_comb begin
    setVec          = '0;
    setVec[F_TXE]   = (txCount <= txTrig);
    setVec[F_RXF]   = (rxCount >= rxTrig);
    setVec[F_DRDY]  = dataReadyEvt;
    setVec[F_ERR]   = rxErrEvt;
    setVec[F_BRK]   = breakEvt;

    dmaClr          = '0;
    dmaClr[F_TXE]   = dmaTxAck && (txCount > txTrig);
    dmaClr[F_RXF]   = dmaRxAck && (rxCount < rxTrig);

    swClr    = {FLAG_N{strobe.wrStatus}} & ~strobe.wrBits & armQ;
    flagNext = setVec | (flagVec & ~(swClr | dmaClr));
    armNext  = flagNext & (armQ | ({FLAG_N{strobe.rdStatus}} & flagVec));
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flagVec[i] <= FLAG_RST[i];
        armQ[i]    <= 1'b0;
      end else begin
        flagVec[i] <= flagNext[i];
        armQ[i]    <= armNext[i];
      end
    end
  end
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txTrig,
  input  logic [CNT_W-1:0]  rxTrig,
  input  logic              dmaTxAck,
  input  logic              dmaRxAck,
  input  logic              dataReadyEvt,
  input  logic              rxErrEvt,
  input  logic              breakEvt,
  input  logic              regRd,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [FLAG_N-1:0] regWdata,
  output logic [FLAG_N-1:0] regRdata,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqErr,
  output logic              irqBrk,
  output logic              dmaTxReq,
  output logic              dmaRxReq,
  output logic              topValid,
  output logic [1:0]        topCode
);
  regStrobe_t        strobe;
  logic              txIe, rxIe;
  logic [FLAG_N-1:0] flagVec;

  uirq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .strobe(strobe),
    .txIe(txIe), .rxIe(rxIe)
  );

  uirq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .txCount(txCount), .rxCount(rxCount), .txTrig(txTrig), .rxTrig(rxTrig),
    .dmaTxAck(dmaTxAck), .dmaRxAck(dmaRxAck),
    .dataReadyEvt(dataReadyEvt), .rxErrEvt(rxErrEvt), .breakEvt(breakEvt),
    .flagVec(flagVec)
  );

  assign regRdata = regAddr ? {{(FLAG_N-2){1'b0}}, rxIe, txIe} : flagVec;

  assign irqTx    = flagVec[F_TXE] & txIe;
  assign irqRx    = (flagVec[F_RXF] | flagVec[F_DRDY]) & rxIe;
  assign irqErr   = flagVec[F_ERR] & rxIe;
  assign irqBrk   = flagVec[F_BRK] & rxIe;
  assign dmaTxReq = flagVec[F_TXE] & txIe;
  assign dmaRxReq = flagVec[F_RXF] & rxIe;

  always_comb begin
    topValid = 1'b1;
    topCode  = SRC_ERR;
    if (irqErr)      topCode = SRC_ERR;
    else if (irqRx)  topCode = SRC_RX;
    else if (irqBrk) topCode = SRC_BRK;
    else if (irqTx)  topCode = SRC_TX;
    else             topValid = 1'b0;
  end
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  txTrig,
  input logic              dmaTxAck,
  input logic              dmaRxAck,
  input logic              regWr,
  input logic              regAddr,
  input logic [FLAG_N-1:0] regWdata,
  input logic [FLAG_N-1:0] flagVec,
  input logic              txIe,
  input logic              rxIe,
  input logic              irqTx,
  input logic              irqRx,
  input logic              irqErr,
  input logic              irqBrk,
  input logic              dmaTxReq,
  input logic              dmaRxReq,
  input logic              topValid,
  input logic [1:0]        topCode
);
  a_r2_tx_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (txCount <= txTrig) |=> flagVec[F_TXE]);

  a_r4_brk_needs_write0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flagVec[F_BRK]) |-> $past(regWr && !regAddr && !regWdata[F_BRK]));

  a_r5_ones_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && !regAddr && (&regWdata) && !dmaTxAck && !dmaRxAck)
      |=> (($past(flagVec) & ~flagVec) == '0));

  a_r8_tx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irqTx == (flagVec[F_TXE] && txIe));

  a_r9_rx_dma_source: assert property (@(posedge clk) disable iff (!rst_n)
    dmaRxReq |-> (flagVec[F_RXF] && rxIe));

  a_r9_tx_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !txIe |-> !dmaTxReq);

  a_r10_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irqErr |-> (topValid && topCode == 2'd0));

  a_r10_tx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (topValid && topCode == 2'd3) |-> (irqTx && !irqErr && !irqRx && !irqBrk));
endmodule

bind uart_irq_flags uirq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txCount(txCount), .txTrig(txTrig),
  .dmaTxAck(dmaTxAck), .dmaRxAck(dmaRxAck), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .flagVec(flagVec), .txIe(txIe), .rxIe(rxIe),
  .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr), .irqBrk(irqBrk),
  .dmaTxReq(dmaTxReq), .dmaRxReq(dmaRxReq), .topValid(topValid), .topCode(topCode)
);

// File: tb/tb_uart_irq_flags.sv
`timescale 1ns/1ps
module tb_uart_irq_flags;
  localparam int CNT_W = 5;
  localparam int FMAX  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] txCount = '0, rxCount = '0, txTrig = '0, rxTrig = '0;
  logic dmaTxAck = 0, dmaRxAck = 0, dataReadyEvt = 0, rxErrEvt = 0, breakEvt = 0;
  logic regRd = 0, regWr = 0, regAddr = 0;
  logic [4:0] regWdata = '0;
  logic [4:0] regRdata;
  logic irqTx, irqRx, irqErr, irqBrk, dmaTxReq, dmaRxReq, topValid;
  logic [1:0] topCode;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  uart_irq_flags #(.CNT_W(CNT_W)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [4:0] d);
    regRd = 1; regAddr = a; #1; d = regRdata; step(); regRd = 0;
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    regWr = 1; regAddr = a; regWdata = d; step(); regWr = 0;
  endtask

  task automatic neutral();
    txCount = FMAX; txTrig = 0; rxCount = 0; rxTrig = FMAX;
  endtask

  task automatic clearAll();
    logic [4:0] d;
    neutral(); step();
    rd(0, d); wr(0, 5'b00000);
  endtask

  task automatic pulse(input int which);
    case (which)
      2: dataReadyEvt = 1;
      3: rxErrEvt = 1;
      default: breakEvt = 1;
    endcase
    step();
    dataReadyEvt = 0; rxErrEvt = 0; breakEvt = 0;
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [4:0] d;
    step(); step();
    rst_n = 1; #1;
    // R1 reset state
    regAddr = 0; #1; chk("R1 status", regRdata, 1);
    regAddr = 1; #1; chk("R1 control", regRdata, 0);
    chk("R1 lines", {irqTx, irqRx, irqErr, irqBrk, dmaTxReq, dmaRxReq, topValid}, 0);
    step();

    // R2 transmit level sweep
    rxCount = 0; rxTrig = FMAX;
    for (int t = 0; t < FMAX; t++) begin
      for (int c = 0; c <= FMAX; c++) begin
        txTrig = t; txCount = FMAX; step();
        rd(0, d); wr(0, 5'b11110);
        txCount = c; step();
        regAddr = 0; #1;
        chk("R2 tx level", regRdata[0], (c <= t) ? 1 : 0);
      end
    end

    // R2 receive level sweep
    txCount = FMAX; txTrig = 0;
    for (int t = 1; t <= FMAX; t++) begin
      for (int c = 0; c <= FMAX; c++) begin
        rxTrig = t; rxCount = 0; step();
        rd(0, d); wr(0, 5'b11101);
        rxCount = c; step();
        regAddr = 0; #1;
        chk("R2 rx level", regRdata[1], (c >= t) ? 1 : 0);
      end
    end

    // R3 events set flags and hold
    clearAll();
    for (int b = 2; b <= 4; b++) begin
      pulse(b); step();
      regAddr = 0; #1;
      chk("R3 event flag", regRdata[b], 1);
    end

    // R4 write 0 without read does nothing, read then write 0 clears
    clearAll(); pulse(4);
    wr(0, 5'b00000); regAddr = 0; #1;
    chk("R4 unarmed write0", regRdata[4], 1);
    rd(0, d); wr(0, 5'b01111); regAddr = 0; #1;
    chk("R4 armed write0", regRdata[4], 0);
    // R4 arm is lost when the flag is re-set after clearing
    pulse(3); rd(0, d); wr(0, 5'b10111); pulse(3);
    wr(0, 5'b00000); regAddr = 0; #1;
    chk("R4 rearm needed", regRdata[3], 1);

    // R5 writing ones leaves flags
    clearAll(); pulse(2); pulse(3); pulse(4);
    rd(0, d); wr(0, 5'b11111); regAddr = 0; #1;
    chk("R5 ones no effect", regRdata, 5'b11100);

    // R11 level set beats software clear
    clearAll(); txTrig = 4; txCount = 2; step();
    rd(0, d); wr(0, 5'b00000); regAddr = 0; #1;
    chk("R11 tx set wins", regRdata[0], 1);
    neutral(); rxTrig = 3; rxCount = 5; step();
    rd(0, d); wr(0, 5'b00000); regAddr = 0; #1;
    chk("R11 rx set wins", regRdata[1], 1);

    // R6 DMA clear of transmit-empty
    clearAll(); txTrig = 4; txCount = 3; step();
    dmaTxAck = 1; step(); dmaTxAck = 0; regAddr = 0; #1;
    chk("R6 no clear at/below trig", regRdata[0], 1);
    txCount = 5; step(); regAddr = 0; #1;
    chk("R6 holds without ack", regRdata[0], 1);
    dmaTxAck = 1; step(); dmaTxAck = 0; regAddr = 0; #1;
    chk("R6 dma clears", regRdata[0], 0);

    // R7 DMA clear of receive-full
    clearAll(); rxTrig = 6; rxCount = 6; step();
    dmaRxAck = 1; step(); dmaRxAck = 0; regAddr = 0; #1;
    chk("R7 no clear at/above trig", regRdata[1], 1);
    rxCount = 5; step(); regAddr = 0; #1;
    chk("R7 holds without ack", regRdata[1], 1);
    dmaRxAck = 1; step(); dmaRxAck = 0; regAddr = 0; #1;
    chk("R7 dma clears", regRdata[1], 0);

    // R8 R9 R10 sweep of all flag patterns and enables
    for (int p = 0; p < 32; p++) begin
      clearAll();
      if (p[0]) begin txCount = 0; step(); txCount = FMAX; end
      if (p[1]) begin rxCount = FMAX; step(); rxCount = 0; end
      for (int b = 2; b <= 4; b++) if (p[b]) pulse(b);
      for (int e = 0; e < 4; e++) begin
        int eTx, eRx, iTx, iRx, iErr, iBrk, ev, ec;
        wr(1, 5'(e));
        eTx = e & 1; eRx = (e >> 1) & 1;
        iTx  = p[0] & eTx;
        iRx  = (p[1] | p[2]) & eRx;
        iErr = p[3] & eRx;
        iBrk = p[4] & eRx;
        ev = iTx | iRx | iErr | iBrk;
        ec = iErr ? 0 : iRx ? 1 : iBrk ? 2 : iTx ? 3 : 0;
        regAddr = 1; #1;
        chk("R8 control readback", regRdata, e);
        chk("R8 irq lines", {irqTx, irqRx, irqErr, irqBrk}, (iTx << 3) | (iRx << 2) | (iErr << 1) | iBrk);
        chk("R9 dma lines", {dmaTxReq, dmaRxReq}, ((p[0] & eTx) << 1) | (p[1] & eRx));
        chk("R10 valid", topValid, ev);
        if (ev != 0) chk("R10 code", topCode, ec);
      end
      wr(1, 5'b00000);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule